// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block decides where a memory transaction that falls in the legacy area between 768 KB and 1 MB is sent: to main memory (DRAM) or onward to the PCI bus. Software programs seven byte-wide attribute registers through a small configuration port. Each register holds the attributes for one or two address regions. Every region has its own read enable and write enable, so a region can be disabled, read-only, write-only or read/write. The enables apply only to requests from the host processor. Requests from any other initiator always go to memory.

A request enters on a valid/ready stream with its address, direction and initiator. After one register stage a verdict leaves on a second valid/ready stream. Back-pressure works as follows. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the verdict holds steady. The verdict is built from the register contents in the cycle the request is taken.

The block does not decode addresses below C0000h or at or above 100000h, which includes the A0000h–BFFFFh hole. For these it flags the verdict as not its own.

Top module: `legacy_attr_router`

## Requirements
- R1: After reset every attribute register reads 00h and `rsp_valid` is low.
- R2: A configuration write to offsets 90h–96h stores the byte. Reads return it with the reserved bits forced to zero. In each nibble, bit 0 is the read enable, bit 1 is the write enable, and bits 2–3 are reserved. At offset 90h the low nibble is also reserved, so a write of FFh there reads back 30h and a write of FFh elsewhere reads back 33h.
- R3: A configuration write to any offset outside 90h–96h changes no register and no routing. A read outside that range returns 00h.
- R4: Region mapping works as follows. F0000h–FFFFFh uses the high nibble of offset 90h. C0000h–EFFFFh is split into twelve 16 KB regions in ascending order. Offsets 91h–96h each cover two of these regions: the low nibble covers the lower region and the high nibble covers the upper one.
- R5: A host read (`req_src` = 0, `req_write` = 0) to a decoded region gives `rsp_to_dram` equal to that region's read enable.
- R6: A host write (`req_src` = 0, `req_write` = 1) to a decoded region gives `rsp_to_dram` equal to that region's write enable.
- R7: A request from a non-host initiator (`req_src` 1 = graphics port, 2 = PCI, 3 = hub link) to a decoded region gives `rsp_to_dram` = 1, whatever the attribute bits are.
- R8: A request to an undecoded address (below C0000h or at or above 100000h) gives `rsp_not_mine` = 1 and `rsp_to_dram` = 0. For a decoded address, `rsp_not_mine` is 0.
- R9: Each accepted request produces exactly one verdict, in order, one cycle after acceptance. `req_ready` = !`rsp_valid` || `rsp_ready`. A verdict held by back-pressure does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Register value at `cfg_off` (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_addr | input | ADDR_W (32) | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 2 | Initiator: 0 host, 1 graphics port, 2 PCI, 3 hub link |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Verdict consumer ready |
| rsp_to_dram | output | 1 | 1 = claim for main memory, 0 = forward to PCI |
| rsp_not_mine | output | 1 | Address outside the decoded window |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, seven 8-bit registers and base offset 90h. The wide address lets it drive requests above 1 MB and at the all-ones address, as well as at the A0000h–BFFFFh hole. Because there are seven registers, the first and last region boundaries and the offsets just outside 90h–96h can all be reached. A random back-pressure pattern on `rsp_ready` makes the verdict hold, so the stream ordering and stability rules get tested while all four attribute modes are swept on every region.

// File: rtl/legacy_attr_pkg.sv
package legacy_attr_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_GFX  = 2'd1,
    SRC_PCI  = 2'd2,
    SRC_HUB  = 2'd3
  } src_e;

  typedef struct packed {
    logic wr_en;
    logic rd_en;
  } attr_t;

  typedef struct packed {
    logic to_dram;
    logic not_mine;
  } verdict_t;
endpackage

// File: rtl/lar_cfg_regs.sv
module lar_cfg_regs #(
  parameter int          NUM_REGS = 7,
  parameter int          DATA_W   = 8,
  parameter int          OFF_W    = 8,
  parameter logic [7:0]  BASE_OFF = 8'h90
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [OFF_W-1:0]           off,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [NIB_W-1:0]  NIB_MASK  = NIB_W'(2'b11);
  localparam logic [DATA_W-1:0] MASK_TOP  = {NIB_MASK, {NIB_W{1'b0}}};
  localparam logic [DATA_W-1:0] MASK_PAIR = {NIB_MASK, NIB_MASK};
  localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(BASE_OFF) + OFF_W'(NUM_REGS - 1);

  logic             hit;
  logic [OFF_W-1:0] idx;

  assign hit = (off >= OFF_W'(BASE_OFF)) && (off <= LAST_OFF);
  assign idx = off - OFF_W'(BASE_OFF);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = (r == 0) ? MASK_TOP : MASK_PAIR;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (we && hit && (idx == OFF_W'(r)))
        q <= wdata & MASK;
    end
    assign regs_flat[r*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (hit && (idx == OFF_W'(r)))
        rdata = regs_flat[r*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/lar_seg_decode.sv
module lar_seg_decode
  import legacy_attr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 7,
  parameter int DATA_W   = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output attr_t                      attr,
  output logic                       miss
);
  localparam int NIB_W     = DATA_W / 2;
  localparam int SEG_SHIFT = 14;           // 16 KB granule
  localparam int LOW_SEG   = 'hC0000 >> SEG_SHIFT;
  localparam int TOP_SEG   = 'hF0000 >> SEG_SHIFT;
  localparam int END_SEG   = 'h100000 >> SEG_SHIFT;
  localparam int NUM_ENT   = 2 * NUM_REGS;

  logic [ADDR_W-1:0] seg;
  logic              in_top, in_mid;
  int                ent;

  assign seg    = addr >> SEG_SHIFT;
  assign in_top = (seg >= ADDR_W'(TOP_SEG)) && (seg < ADDR_W'(END_SEG));
  assign in_mid = (seg >= ADDR_W'(LOW_SEG)) && (seg < ADDR_W'(TOP_SEG));

  always_comb begin
    ent = 1;
    if (in_mid)
      ent = int'(seg - ADDR_W'(LOW_SEG)) + 2;
    miss = !(in_top || (in_mid && ent < NUM_ENT));
    if (miss)
      ent = 1;
    attr.rd_en = regs_flat[ent*NIB_W];
    attr.wr_en = regs_flat[ent*NIB_W + 1];
  end
endmodule

// File: rtl/lar_route_stage.sv
module lar_route_stage
  import legacy_attr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  attr_t    attr,
  input  logic     miss,
  input  logic     is_write,
  input  src_e     src,
  output logic     out_valid,
  input  logic     out_ready,
  output verdict_t verdict
);
  verdict_t next_v;
  logic     take;

  always_comb begin
    next_v.not_mine = miss;
    if (miss)
      next_v.to_dram = 1'b0;
    else if (src != SRC_HOST)
      next_v.to_dram = 1'b1;
    else
      next_v.to_dram = is_write ? attr.wr_en : attr.rd_en;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      verdict   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        verdict   <= next_v;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/legacy_attr_router.sv
module legacy_attr_router
  import legacy_attr_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter int         NUM_REGS = 7,
  parameter int         DATA_W   = 8,
  parameter int         OFF_W    = 8,
  parameter logic [7:0] BASE_OFF = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_src,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_to_dram,
  output logic              rsp_not_mine
);
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  attr_t                      attr;
  logic                       miss;
  verdict_t                   verdict;

  lar_cfg_regs #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .OFF_W(OFF_W), .BASE_OFF(BASE_OFF)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .off(cfg_off),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs_flat(regs_flat)
  );

  lar_seg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) dec_i (
    .addr(req_addr), .regs_flat(regs_flat), .attr(attr), .miss(miss)
  );

  lar_route_stage stage_i (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .attr(attr), .miss(miss), .is_write(req_write), .src(src_e'(req_src)),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .verdict(verdict)
  );

  assign rsp_to_dram  = verdict.to_dram;
  assign rsp_not_mine = verdict.not_mine;
endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_src,
  input logic [7:0]        cfg_off,
  input logic [7:0]        cfg_rdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_to_dram,
  input logic              rsp_not_mine
);
  logic in_win, acc;
  assign in_win = (req_addr >= ADDR_W'('hC0000)) && (req_addr < ADDR_W'('h100000));
  assign acc    = req_valid && req_ready;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'hCC) == 8'h00);

  a_r3_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_off < 8'h90 || cfg_off > 8'h96) |-> cfg_rdata == 8'h00);

  a_r7_nonhost_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_win && req_src != 2'd0) |=> rsp_to_dram && !rsp_not_mine);

  a_r8_undecoded_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_win) |=> rsp_not_mine);

  a_r8_not_mine_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_not_mine) |-> !rsp_to_dram);

  a_r9_accept_gives_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_to_dram) && $stable(rsp_not_mine));
endmodule

bind legacy_attr_router lar_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_src(req_src), .cfg_off(cfg_off), .cfg_rdata(cfg_rdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_to_dram(rsp_to_dram),
  .rsp_not_mine(rsp_not_mine)
);

// File: tb/legacy_attr_router_tb.sv
module legacy_attr_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_off = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_src = 2'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_to_dram;
  logic        rsp_not_mine;

  legacy_attr_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_src(req_src), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_to_dram(rsp_to_dram), .rsp_not_mine(rsp_not_mine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic  dram;
    logic  nm;
    string tag;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] mdl[7];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;
  bit         bp_on = 0;
  logic [7:0] lfsr = 8'h5A;
  bit         hold_seen = 0;
  logic       hold_d, hold_nm;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  function automatic exp_t predict(logic [31:0] a, bit wr, logic [1:0] src, string tag);
    exp_t p;
    logic [3:0] nib;
    int k;
    p.tag = tag;
    if (a < 32'hC0000 || a > 32'hFFFFF) begin
      p.nm = 1; p.dram = 0;
      return p;
    end
    if (a >= 32'hF0000) nib = mdl[0][7:4];
    else begin
      k = int'((a - 32'hC0000) / 32'h4000);
      nib = (k % 2 == 1) ? mdl[1 + k/2][7:4] : mdl[1 + k/2][3:0];
    end
    p.nm = 0;
    p.dram = (src != 2'd0) ? 1'b1 : (wr ? nib[1] : nib[0]);
    return p;
  endfunction

  // Monitor: chooses back-pressure, checks hold and pops the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_seen)
        chk(rsp_valid && rsp_to_dram == hold_d && rsp_not_mine == hold_nm,
            "R9", "held verdict", {rsp_valid, rsp_to_dram, rsp_not_mine},
            {1'b1, hold_d, hold_nm});
      rsp_ready = bp_on ? lfsr[0] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      hold_seen = rsp_valid && !rsp_ready;
      hold_d = rsp_to_dram;
      hold_nm = rsp_not_mine;
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0)
          chk(0, "R9", "unexpected verdict", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_to_dram == e.dram && rsp_not_mine == e.nm, e.tag,
              "verdict {dram,not_mine}", {rsp_to_dram, rsp_not_mine}, {e.dram, e.nm});
        end
      end
    end
  end

  task automatic cfg_wr(logic [7:0] off, logic [7:0] data);
    @(negedge clk); #1;
    cfg_we = 1; cfg_off = off; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 0;
    if (off >= 8'h90 && off <= 8'h96)
      mdl[off - 8'h90] = data & ((off == 8'h90) ? 8'h30 : 8'h33);
  endtask

  task automatic cfg_rd(logic [7:0] off, string tag);
    logic [7:0] e;
    @(negedge clk); #1;
    cfg_off = off; #1;
    e = (off >= 8'h90 && off <= 8'h96) ? mdl[off - 8'h90] : 8'h00;
    chk(cfg_rdata == e, tag, "cfg read", cfg_rdata, e);
  endtask

  task automatic send(logic [31:0] a, bit wr, logic [1:0] src, string tag);
    @(negedge clk); #1;
    req_valid = 1; req_addr = a; req_write = wr; req_src = src;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    sb.push_back(predict(a, wr, src, tag));
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] seg_base(int s);
    return (s == 12) ? 32'hF0000 : 32'hC0000 + 32'(s) * 32'h4000;
  endfunction

  function automatic logic [31:0] seg_last(int s);
    return (s == 12) ? 32'hFFFFF : seg_base(s) + 32'h3FFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "WDOG", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    for (int i = 0; i < 7; i++) cfg_rd(8'h90 + 8'(i), "R1");

    // R2: reserved bits masked
    for (int i = 0; i < 7; i++) cfg_wr(8'h90 + 8'(i), 8'hFF);
    for (int i = 0; i < 7; i++) cfg_rd(8'h90 + 8'(i), "R2");
    cfg_wr(8'h93, 8'hA6);
    cfg_rd(8'h93, "R2");

    // R3: out-of-range writes ignored
    cfg_wr(8'h91, 8'h00);
    cfg_wr(8'h8F, 8'hFF);
    cfg_wr(8'h97, 8'hFF);
    cfg_wr(8'h00, 8'hFF);
    cfg_wr(8'h11, 8'hFF);
    for (int i = 0; i < 7; i++) cfg_rd(8'h90 + 8'(i), "R3");
    cfg_rd(8'h8F, "R3");
    cfg_rd(8'h97, "R3");
    send(32'hC0000, 0, 2'd0, "R3");
    send(32'hC7FFF, 1, 2'd0, "R3");
    drain();

    // R5/R6: all four modes on every region, with back-pressure
    bp_on = 1;
    for (int m = 0; m < 4; m++) begin
      cfg_wr(8'h90, 8'(m << 4));
      for (int i = 1; i < 7; i++) cfg_wr(8'h90 + 8'(i), 8'(m | (m << 4)));
      for (int s = 0; s < 13; s++) begin
        send(seg_base(s), 0, 2'd0, "R5");
        send(seg_last(s), 1, 2'd0, "R6");
      end
    end
    drain();

    // R4: distinct mode per region exposes mapping
    for (int r = 0; r < 7; r++)
      cfg_wr(8'h90 + 8'(r), 8'((((2*r + 1) % 4) << 4) | ((3*r + 2) % 4)));
    for (int s = 0; s < 13; s++) begin
      send(seg_base(s), 0, 2'd0, "R4");
      send(seg_base(s) + 32'h2000, 1, 2'd0, "R4");
      send(seg_last(s), 0, 2'd0, "R4");
      send(seg_last(s), 1, 2'd0, "R4");
    end
    drain();

    // R7: non-host always to memory, even with attributes cleared
    for (int i = 0; i < 7; i++) cfg_wr(8'h90 + 8'(i), 8'h00);
    for (int s = 0; s < 13; s++)
      for (int src = 1; src < 4; src++) begin
        send(seg_base(s), 0, 2'(src), "R7");
        send(seg_last(s), 1, 2'(src), "R7");
      end
    send(32'hD4000, 0, 2'd0, "R7");
    drain();

    // R8: undecoded addresses
    cfg_wr(8'h96, 8'h33);
    cfg_wr(8'h91, 8'h33);
    send(32'h00000000, 0, 2'd0, "R8");
    send(32'h0009FFFF, 1, 2'd1, "R8");
    send(32'h000A0000, 0, 2'd0, "R8");
    send(32'h000BFFFF, 1, 2'd0, "R8");
    send(32'h000C0000, 0, 2'd0, "R8");
    send(32'h000EFFFF, 1, 2'd0, "R8");
    send(32'h00100000, 0, 2'd2, "R8");
    send(32'hFFFFFFFF, 1, 2'd0, "R8");
    send(32'h001F0000, 0, 2'd3, "R8");
    drain();

    // R9: back-to-back stream with no back-pressure
    bp_on = 0;
    for (int s = 0; s < 13; s++) send(seg_base(s), s % 2, 2'(s % 4), "R9");
    drain();
    chk(sb.size() == 0 && rsp_valid == 0, "R9", "stream drained",
        {sb.size() != 0, rsp_valid}, 0);

    summary();
    $finish;
  end
endmodule